// File: doc/BRIEF.md
# Demand-Cached Page Mapping Translator

This block turns logical page numbers into physical page numbers for a flash storage controller. It keeps the mappings in use in a small on-chip cache. The complete page-level table stays in flash, spread over translation pages. Each translation page covers 512 consecutive logical pages. An on-chip directory records where each translation page currently sits in flash.

A lookup that hits returns the physical page on the next cycle. A lookup that misses first frees a cache slot. A clean victim is simply overwritten. A dirty victim is written back with a read-modify-program sequence to a freshly allocated translation page. Every other dirty entry of the same translation page is folded into that one program. The block then reads the wanted mapping from flash, installs it and completes the lookup.

A write request takes a new physical data page from the allocator and records it as a dirty mapping. Requests that span several pages are walked one logical page at a time. Only one request is in flight at a time.

Top module: `ftl_map_xlate`

## Requirements
- R1: After reset the cache holds no entries, translation page i is located at physical page i, `req_ready` is high, and no flash command or response is issued.
- R2: A logical page splits into a translation page index (`lpn >> 9`) and an entry offset (`lpn[8:0]`). The miss fetch is a read command (`fc_op`=0) to the directory location of that index, carrying the offset in `fc_off`.
- R3: A lookup that hits the cache produces its response in the cycle after the request is accepted, with no flash command.
- R4: A miss whose victim slot is empty or clean issues exactly one flash read and no load, patch or program command.
- R5: A miss whose victim is dirty issues, in this order:
  - a page load (`fc_op`=1) from the directory location of the victim's translation page;
  - patches (`fc_op`=2);
  - a program (`fc_op`=3) to the page offered by the allocator.
  The directory entry then points at the new page, and the fetch read follows.
- R6: The write-back patches every dirty cached entry of the victim's translation page, each with its offset and physical page, and leaves those entries clean.
- R7: A write request responds with the allocator's page, pulses `alloc_take`, and later reads of that logical page return the new page.
- R8: New entries enter the probationary segment. A hit on a probationary entry moves it to the protected segment. The victim is the least recently used probationary entry, or the least recently used entry overall if no probationary entry exists.
- R9: A request with count n yields n responses for logical pages lpn, lpn+1, … in order, and may cross translation page boundaries. A count of zero yields none.
- R10: `req_ready` stays low from acceptance until the last response of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_lpn | input | LPN_W | First logical page |
| req_cnt | input | CNT_W | Number of pages |
| req_write | input | 1 | 1 = write request |
| rsp_valid | output | 1 | One translated page this cycle |
| rsp_lpn | output | LPN_W | Logical page of the response |
| rsp_ppn | output | PPN_W | Physical page of the response |
| fc_valid | output | 1 | Flash command valid |
| fc_ready | input | 1 | Flash command accepted |
| fc_op | output | 2 | 0 read entry, 1 load page, 2 patch entry, 3 program page |
| fc_page | output | PPN_W | Physical translation page addressed |
| fc_off | output | 9 | Entry offset in the page |
| fc_data | output | PPN_W | Patch data |
| fr_valid | input | 1 | Read data returned |
| fr_data | input | PPN_W | Mapping read from flash |
| alloc_valid | input | 1 | Allocator has a free page |
| alloc_ppn | input | PPN_W | Free page offered |
| alloc_take | output | 1 | Offered page consumed |

## Verification
The bench drives a request that crosses the 511/512 boundary between translation pages. A design that split the address wrongly would fetch from the wrong page or the wrong offset.

It builds a cache holding two dirty entries of one translation page, then evicts one of them. A design that skipped the fold would issue only one patch. A design that forgot to move the directory would later fetch a stale mapping, and the bench sees that as a wrong physical page after the round trip through flash.

It also promotes entries and then forces evictions. A victim choice that ignores the segments would evict a protected entry, and a later read of it would cost a flash read.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    // entries per translation page: 2 KB data area / 4-byte mappings
    localparam int unsigned OFF_W = 9;

    typedef enum logic [1:0] {
        FL_READ  = 2'd0,
        FL_LOAD  = 2'd1,
        FL_PATCH = 2'd2,
        FL_PROG  = 2'd3
    } fl_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_WB_LOAD,
        S_WB_PATCH,
        S_WB_PROG,
        S_FETCH,
        S_WAIT
    } xl_state_e;

endpackage

// File: rtl/ftl_dir.sv
module ftl_dir #(
    parameter int unsigned NTP   = 4,
    parameter int unsigned PPN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [$clog2(NTP)-1:0] rd_idx,
    output logic [PPN_W-1:0]       rd_ppn,
    input  logic                   wr_en,
    input  logic [$clog2(NTP)-1:0] wr_idx,
    input  logic [PPN_W-1:0]       wr_ppn
);
    localparam int unsigned TW = $clog2(NTP);

    logic [PPN_W-1:0] tbl [NTP];

    for (genvar g = 0; g < NTP; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                tbl[g] <= PPN_W'(g);
            else if (wr_en && wr_idx == TW'(g))
                tbl[g] <= wr_ppn;
        end
    end

    assign rd_ppn = tbl[rd_idx];

    AST_FRESH_PAGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_ppn != tbl[wr_idx]); // R5

endmodule

// File: rtl/ftl_cache.sv
module ftl_cache #(
    parameter int unsigned N     = 4,
    parameter int unsigned LPN_W = 11,
    parameter int unsigned PPN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LPN_W-1:0]     look_lpn,
    output logic                 hit,
    output logic [$clog2(N)-1:0] hit_idx,
    output logic                 hit_prot,
    output logic [PPN_W-1:0]     hit_ppn,
    output logic [$clog2(N)-1:0] vic_idx,
    output logic                 vic_valid,
    output logic                 vic_dirty,
    output logic [LPN_W-1:0]     vic_lpn,
    input  logic [$clog2(N)-1:0] scan_idx,
    output logic                 scan_valid,
    output logic                 scan_dirty,
    output logic [LPN_W-1:0]     scan_lpn,
    output logic [PPN_W-1:0]     scan_ppn,
    input  logic                 upd_en,
    input  logic [$clog2(N)-1:0] upd_idx,
    input  logic                 upd_wr,
    input  logic [PPN_W-1:0]     upd_ppn,
    input  logic                 upd_promote,
    input  logic                 fill_en,
    input  logic [$clog2(N)-1:0] fill_idx,
    input  logic [LPN_W-1:0]     fill_lpn,
    input  logic [PPN_W-1:0]     fill_ppn,
    input  logic                 clr_en,
    input  logic [$clog2(N)-1:0] clr_idx
);
    localparam int unsigned IW = $clog2(N);

    logic [N-1:0]     v, d, p, hv;
    logic [LPN_W-1:0] lp [N];
    logic [PPN_W-1:0] pp [N];
    logic [IW-1:0]    rk [N];   // 0 = most recently used

    logic          t_en;
    logic [IW-1:0] t_idx, t_old;
    assign t_en  = upd_en || fill_en;
    assign t_idx = fill_en ? fill_idx : upd_idx;
    assign t_old = rk[t_idx];

    for (genvar g = 0; g < N; g++) begin : g_ent
        assign hv[g] = v[g] && lp[g] == look_lpn;

        always_ff @(posedge clk) begin
            if (rst) begin
                v[g]  <= 1'b0;
                d[g]  <= 1'b0;
                p[g]  <= 1'b0;
                lp[g] <= '0;
                pp[g] <= '0;
                rk[g] <= IW'(g);
            end else begin
                if (t_en) begin
                    if (t_idx == IW'(g))
                        rk[g] <= '0;
                    else if (rk[g] < t_old)
                        rk[g] <= rk[g] + 1'b1;
                end
                if (fill_en && fill_idx == IW'(g)) begin
                    v[g]  <= 1'b1;
                    d[g]  <= 1'b0;
                    p[g]  <= 1'b0;
                    lp[g] <= fill_lpn;
                    pp[g] <= fill_ppn;
                end
                if (upd_en && upd_idx == IW'(g)) begin
                    if (upd_wr) begin
                        d[g]  <= 1'b1;
                        pp[g] <= upd_ppn;
                    end
                    if (upd_promote)
                        p[g] <= 1'b1;
                end
                if (clr_en && clr_idx == IW'(g))
                    d[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++)
            if (hv[i]) hit_idx = IW'(i);
    end
    assign hit      = |hv;
    assign hit_prot = p[hit_idx];
    assign hit_ppn  = pp[hit_idx];

    // victim: empty slot, else oldest probationary, else oldest overall
    always_comb begin
        logic got_free, got_prob;
        got_free = 1'b0;
        got_prob = 1'b0;
        vic_idx  = '0;
        for (int i = 0; i < N; i++)
            if (!v[i] && !got_free) begin
                vic_idx  = IW'(i);
                got_free = 1'b1;
            end
        if (!got_free) begin
            for (int i = 0; i < N; i++)
                if (!p[i] && (!got_prob || rk[i] > rk[vic_idx])) begin
                    vic_idx  = IW'(i);
                    got_prob = 1'b1;
                end
            if (!got_prob)
                for (int i = 0; i < N; i++)
                    if (rk[i] > rk[vic_idx]) vic_idx = IW'(i);
        end
    end
    assign vic_valid = v[vic_idx];
    assign vic_dirty = d[vic_idx];
    assign vic_lpn   = lp[vic_idx];

    assign scan_valid = v[scan_idx];
    assign scan_dirty = d[scan_idx];
    assign scan_lpn   = lp[scan_idx];
    assign scan_ppn   = pp[scan_idx];

    logic [N-1:0] rmask;
    always_comb begin
        rmask = '0;
        for (int i = 0; i < N; i++) rmask[rk[i]] = 1'b1;
    end

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hv)); // R3
    AST_RANK_PERM: assert property (@(posedge clk) disable iff (rst)
        $countones(rmask) == N); // R8

endmodule

// File: rtl/ftl_map_xlate.sv
module ftl_map_xlate
    import ftl_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    parameter int unsigned LPN_W = 11,
    parameter int unsigned PPN_W = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LPN_W-1:0] req_lpn,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [LPN_W-1:0] rsp_lpn,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             fc_valid,
    input  logic             fc_ready,
    output logic [1:0]       fc_op,
    output logic [PPN_W-1:0] fc_page,
    output logic [OFF_W-1:0] fc_off,
    output logic [PPN_W-1:0] fc_data,
    input  logic             fr_valid,
    input  logic [PPN_W-1:0] fr_data,
    input  logic             alloc_valid,
    input  logic [PPN_W-1:0] alloc_ppn,
    output logic             alloc_take
);
    localparam int unsigned TP_W = LPN_W - OFF_W;
    localparam int unsigned NTP  = 1 << TP_W;
    localparam int unsigned IW   = $clog2(N_ENT);

    xl_state_e        st;
    logic [LPN_W-1:0] cur_lpn;
    logic [CNT_W-1:0] left;
    logic             wr_q, fresh_q;
    logic [IW-1:0]    vic_q, scan_q;
    logic [TP_W-1:0]  vtp_q;

    logic             hit, hit_prot, vic_valid, vic_dirty;
    logic [IW-1:0]    hit_idx, vic_idx;
    logic [PPN_W-1:0] hit_ppn, scan_ppn, dir_ppn;
    logic [LPN_W-1:0] vic_lpn, scan_lpn;
    logic             scan_valid, scan_dirty, scan_hit;
    logic             upd_en, upd_promote, fill_en, clr_en, dir_we, fire;
    logic [TP_W-1:0]  dir_idx;

    ftl_cache #(.N(N_ENT), .LPN_W(LPN_W), .PPN_W(PPN_W)) i_cache (
        .clk, .rst,
        .look_lpn(cur_lpn),
        .hit, .hit_idx, .hit_prot, .hit_ppn,
        .vic_idx, .vic_valid, .vic_dirty, .vic_lpn,
        .scan_idx(scan_q), .scan_valid, .scan_dirty, .scan_lpn, .scan_ppn,
        .upd_en, .upd_idx(hit_idx), .upd_wr(wr_q), .upd_ppn(alloc_ppn),
        .upd_promote,
        .fill_en, .fill_idx(vic_q), .fill_lpn(cur_lpn), .fill_ppn(fr_data),
        .clr_en, .clr_idx(scan_q)
    );

    ftl_dir #(.NTP(NTP), .PPN_W(PPN_W)) i_dir (
        .clk, .rst,
        .rd_idx(dir_idx), .rd_ppn(dir_ppn),
        .wr_en(dir_we), .wr_idx(vtp_q), .wr_ppn(alloc_ppn)
    );

    assign dir_idx  = (st == S_WB_LOAD) ? vtp_q : cur_lpn[LPN_W-1:OFF_W];
    assign scan_hit = scan_valid && scan_dirty && scan_lpn[LPN_W-1:OFF_W] == vtp_q;
    assign fire     = hit && (!wr_q || alloc_valid);
    assign rsp_lpn  = cur_lpn;
    assign rsp_ppn  = wr_q ? alloc_ppn : hit_ppn;

    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        fc_valid    = 1'b0;
        fc_op       = FL_READ;
        fc_page     = dir_ppn;
        fc_off      = cur_lpn[OFF_W-1:0];
        fc_data     = '0;
        alloc_take  = 1'b0;
        upd_en      = 1'b0;
        upd_promote = 1'b0;
        fill_en     = 1'b0;
        clr_en      = 1'b0;
        dir_we      = 1'b0;
        case (st)
            S_IDLE: req_ready = 1'b1;
            S_LOOK: if (fire) begin
                rsp_valid   = 1'b1;
                upd_en      = 1'b1;
                upd_promote = !hit_prot && !fresh_q;
                alloc_take  = wr_q;
            end
            S_WB_LOAD: begin
                fc_valid = 1'b1;
                fc_op    = FL_LOAD;
            end
            S_WB_PATCH: begin
                fc_valid = scan_hit;
                fc_op    = FL_PATCH;
                fc_off   = scan_lpn[OFF_W-1:0];
                fc_data  = scan_ppn;
                clr_en   = scan_hit && fc_ready;
            end
            S_WB_PROG: begin
                fc_valid   = alloc_valid;
                fc_op      = FL_PROG;
                fc_page    = alloc_ppn;
                alloc_take = alloc_valid && fc_ready;
                dir_we     = alloc_valid && fc_ready;
            end
            S_FETCH: fc_valid = 1'b1;
            S_WAIT:  fill_en = fr_valid;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cur_lpn <= '0;
            left    <= '0;
            wr_q    <= 1'b0;
            fresh_q <= 1'b0;
            vic_q   <= '0;
            scan_q  <= '0;
            vtp_q   <= '0;
        end else begin
            case (st)
                S_IDLE: if (req_valid && req_cnt != '0) begin
                    cur_lpn <= req_lpn;
                    left    <= req_cnt;
                    wr_q    <= req_write;
                    fresh_q <= 1'b0;
                    st      <= S_LOOK;
                end
                S_LOOK: begin
                    if (fire) begin
                        fresh_q <= 1'b0;
                        if (left == CNT_W'(1)) begin
                            st <= S_IDLE;
                        end else begin
                            left    <= left - 1'b1;
                            cur_lpn <= cur_lpn + 1'b1;
                        end
                    end else if (!hit) begin
                        vic_q <= vic_idx;
                        vtp_q <= vic_lpn[LPN_W-1:OFF_W];
                        st    <= (vic_valid && vic_dirty) ? S_WB_LOAD : S_FETCH;
                    end
                end
                S_WB_LOAD: if (fc_ready) begin
                    scan_q <= '0;
                    st     <= S_WB_PATCH;
                end
                S_WB_PATCH: if (!scan_hit || fc_ready) begin
                    if (scan_q == IW'(N_ENT - 1))
                        st <= S_WB_PROG;
                    else
                        scan_q <= scan_q + 1'b1;
                end
                S_WB_PROG: if (alloc_valid && fc_ready) st <= S_FETCH;
                S_FETCH:   if (fc_ready) st <= S_WAIT;
                S_WAIT: if (fr_valid) begin
                    fresh_q <= 1'b1;
                    st      <= S_LOOK;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        fc_valid && !fc_ready && st != S_WB_PROG |=> fc_valid && $stable(fc_op)); // R5
    AST_TAKE_VALID: assert property (@(posedge clk) disable iff (rst)
        alloc_take |-> alloc_valid); // R7
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R10
    AST_NO_FILL_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !fc_valid && !rsp_valid); // R1

endmodule

// File: tb/test_ftl_map_xlate.sv
`timescale 1ns/1ps
module test_ftl_map_xlate;
    import ftl_pkg::*;

    localparam int LPN_W = 11;
    localparam int PPN_W = 16;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [LPN_W-1:0] req_lpn = '0, rsp_lpn;
    logic [CNT_W-1:0] req_cnt = '0;
    logic             rsp_valid;
    logic [PPN_W-1:0] rsp_ppn;
    logic             fc_valid, fc_ready;
    logic [1:0]       fc_op;
    logic [PPN_W-1:0] fc_page, fc_data;
    logic [8:0]       fc_off;
    logic             fr_valid = 1'b0;
    logic [PPN_W-1:0] fr_data = '0;
    logic             alloc_valid, alloc_take;
    logic [PPN_W-1:0] alloc_ppn;
    logic [PPN_W-1:0] next_free = 16'd4;

    assign fc_ready    = 1'b1;
    assign alloc_valid = 1'b1;
    assign alloc_ppn   = next_free;

    ftl_map_xlate i_ftl_map_xlate (.*);

    int nchk = 0, nerr = 0;
    bit done = 0;
    int fmem [0:32767];
    int ref_map [0:2047];
    int pbuf [0:511];
    int n_read, n_load, n_patch, n_prog, nseq;
    int seq [0:15];
    int patch_off [0:15];
    int last_rd_page, last_rd_off, last_ld_page, last_prog_page;
    int lat;

    // flash and allocator models
    always @(posedge clk) begin
        fr_valid <= 1'b0;
        if (alloc_take) next_free <= next_free + 1'b1;
        if (fc_valid && fc_ready) begin
            if (nseq < 16) seq[nseq] = int'(fc_op);
            nseq++;
            case (fc_op)
                FL_READ: begin
                    n_read++;
                    last_rd_page = int'(fc_page);
                    last_rd_off  = int'(fc_off);
                    fr_valid <= 1'b1;
                    fr_data  <= PPN_W'(fmem[int'(fc_page[5:0]) * 512 + int'(fc_off)]);
                end
                FL_LOAD: begin
                    n_load++;
                    last_ld_page = int'(fc_page);
                    for (int k = 0; k < 512; k++) pbuf[k] = fmem[int'(fc_page[5:0]) * 512 + k];
                end
                FL_PATCH: begin
                    if (n_patch < 16) patch_off[n_patch] = int'(fc_off);
                    n_patch++;
                    pbuf[fc_off] = int'(fc_data);
                end
                default: begin
                    n_prog++;
                    last_prog_page = int'(fc_page);
                    for (int k = 0; k < 512; k++) fmem[int'(fc_page[5:0]) * 512 + k] = pbuf[k];
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < 2048; l++) ref_map[l] = 32'h8000 | l;
    endtask

    task automatic do_req(input int lpn, input int cnt, input bit wr);
        int got, guard, busy;
        @(negedge clk);
        n_read = 0; n_load = 0; n_patch = 0; n_prog = 0; nseq = 0;
        req_valid = 1'b1;
        req_lpn   = LPN_W'(lpn);
        req_cnt   = CNT_W'(cnt);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; guard = 0; busy = 0; lat = 0;
        while (got < cnt && guard < 2000) begin
            if (req_ready) busy++;
            if (rsp_valid) begin
                int l, exp;
                l = (lpn + got) % 2048;
                if (got == 0) lat = guard + 1;
                chk(int'(rsp_lpn) == l, "R9 response order", int'(rsp_lpn), l);
                if (wr) begin
                    exp = int'(alloc_ppn);
                    ref_map[l] = exp;
                    chk(int'(rsp_ppn) == exp, "R7 write takes allocator page", int'(rsp_ppn), exp);
                end else begin
                    exp = ref_map[l];
                    chk(int'(rsp_ppn) == exp, "R2 read mapping", int'(rsp_ppn), exp);
                end
                got++;
            end
            guard++;
            @(negedge clk);
        end
        chk(got == cnt, "R9 response count", got, cnt);
        chk(busy == 0, "R10 ready low while busy", busy, 0);
    endtask

    typedef struct packed {
        logic [10:0] lpn;
        logic [7:0]  cnt;
        logic        wr;
        logic [3:0]  reads;
        logic [3:0]  progs;
    } vec_t;

    localparam vec_t VT [0:7] = '{
        '{11'h005, 8'd1, 1'b0, 4'd1, 4'd0},
        '{11'h005, 8'd1, 1'b0, 4'd0, 4'd0},
        '{11'h1FE, 8'd3, 1'b0, 4'd3, 4'd0},
        '{11'h1FF, 8'd1, 1'b1, 4'd0, 4'd0},
        '{11'h404, 8'd1, 1'b0, 4'd1, 4'd0},
        '{11'h1FF, 8'd1, 1'b0, 4'd0, 4'd0},
        '{11'h600, 8'd2, 1'b0, 4'd2, 4'd0},
        '{11'h005, 8'd1, 1'b0, 4'd0, 4'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 32768; a++) fmem[a] = (a < 2048) ? (32'h8000 | a) : 0;
        do_reset();
        @(negedge clk);
        // R1: idle state after reset
        chk(req_ready && !fc_valid && !rsp_valid, "R1 reset state",
            {req_ready, fc_valid, rsp_valid}, 3'b100);

        // table walk; R4 clean misses, R3 hits, R9 boundary crossing
        for (int i = 0; i < 8; i++) begin
            do_req(int'(VT[i].lpn), int'(VT[i].cnt), VT[i].wr);
            chk(n_read == int'(VT[i].reads), "R4 flash reads per vector", n_read, int'(VT[i].reads));
            chk(n_prog == int'(VT[i].progs), "R4 no write-back on clean victim", n_prog, int'(VT[i].progs));
        end

        // R2: address split on a fresh cache
        do_reset();
        do_req(32'h405, 1, 1'b0);
        chk(last_rd_page == 2, "R2 directory index", last_rd_page, 2);
        chk(last_rd_off == 5, "R2 entry offset", last_rd_off, 5);
        // R3: hit latency and no traffic
        do_req(32'h405, 1, 1'b0);
        chk(lat == 1 && nseq == 0, "R3 hit one cycle no flash", lat * 16 + nseq, 16);

        // dirty write-back scenario
        do_reset();
        do_req(32'h010, 1, 1'b1);
        do_req(32'h011, 1, 1'b1);
        do_req(32'h200, 1, 1'b0);
        do_req(32'h201, 1, 1'b0);
        do_req(32'h010, 1, 1'b0);   // R8 promote
        chk(n_read == 0, "R8 hit on probationary entry", n_read, 0);
        do_req(32'h400, 1, 1'b0);   // evicts dirty 0x011
        chk(n_load == 1 && last_ld_page == 0, "R5 load from directory location", last_ld_page, 0);
        chk(n_patch == 2, "R6 folded patches", n_patch, 2);
        chk(n_prog == 1 && n_read == 1, "R5 one program one fetch", n_prog * 16 + n_read, 17);
        chk(seq[0] == 1 && seq[3] == 3 && seq[4] == 0, "R5 command order",
            seq[0] * 256 + seq[3] * 16 + seq[4], 16'h0130);
        chk(fmem[(last_prog_page % 64) * 512 + 16'h10] == ref_map[16'h10], "R6 folded entry data",
            fmem[(last_prog_page % 64) * 512 + 16'h10], ref_map[16'h10]);
        chk(fmem[(last_prog_page % 64) * 512 + 16'h11] == ref_map[16'h11], "R5 victim entry data",
            fmem[(last_prog_page % 64) * 512 + 16'h11], ref_map[16'h11]);
        do_req(32'h010, 1, 1'b0);
        chk(n_read == 0, "R8 protected entry kept", n_read, 0);
        do_req(32'h200, 1, 1'b0);
        chk(n_read == 0, "R8 probationary survivor", n_read, 0);
        do_req(32'h011, 1, 1'b0);   // refetch through moved directory
        chk(n_read == 1 && n_prog == 0, "R4 clean victim one read", n_read * 16 + n_prog, 16);
        chk(last_rd_page == last_prog_page, "R5 directory updated", last_rd_page, last_prog_page);
        do_req(32'h600, 1, 1'b0);
        chk(n_prog == 0, "R6 entries left clean", n_prog, 0);
        do_req(32'h010, 1, 1'b0);
        chk(n_read == 0, "R8 protected survives eviction", n_read, 0);
        do_req(32'h011, 1, 1'b0);
        chk(n_read == 0, "R8 newer probationary kept", n_read, 0);

        // R9: zero count yields nothing
        do_req(32'h020, 0, 1'b0);
        chk(nseq == 0 && req_ready, "R9 zero count", nseq, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule